// File: doc/BRIEF.md
# Periodic Tick Timer

This block is a 24-bit down-counter that produces a steady tick for a scheduler or a timeout service. Software sets a start value, the reload, and turns the timer on. The counter then steps down by one on every clock. When it steps from 1 to 0, it sets a sticky event flag and can send a one-cycle interrupt request. On the following clock it loads the reload value again. A reload of N therefore gives one tick every N+1 clocks, and a reload of zero leaves the timer idle.

Three word registers sit on a simple single-cycle register bus, and only privileged transactions reach them:

| Offset | Contents |
|---|---|
| 0x010 | Control and status |
| 0x014 | Reload value |
| 0x018 | Live count |

Writing any data to the live-count register sets the count to zero and drops the flag. This lets software restart a period from a known point.

Top module: `tick_timer`

## Requirements
- R1: After reset, every register reads zero, the timer is disabled and `irq_o` is low.
- R2: While enabled with a reload N from 1 to 0xFFFFFF, the count reads N, N-1, … 1, 0 and then N again. One tick occurs every N+1 clocks, on the step from 1 to 0.
- R3: With a reload of zero, the enabled counter stays at zero. It makes no tick, sets no flag and raises no interrupt.
- R4: The control register at 0x010 has these fields:
  - bit 0: enable
  - bit 1: interrupt enable
  - bit 16: the event flag

  Every tick sets the flag, and the flag stays set. A privileged read of 0x010 returns the flag and then clears it. A write to 0x010 does not change the flag.
- R5: `irq_o` is high for exactly one clock. That clock is the cycle after the counter reaches zero, and `irq_o` only rises when interrupt enable is set. With interrupt enable clear, a tick still sets the flag but `irq_o` stays low.
- R6: A privileged write of any data to 0x018 sets the count to zero and clears the flag. The next enabled clock loads the reload value and does not produce a tick.
- R7: Reading 0x018 returns the live count. Both 0x014 and 0x018 hold a 24-bit value in bits 23:0, and bits 31:24 read as zero. An address outside the three offsets reads as zero.
- R8: While the timer is disabled, the count keeps its value.
- R9: A new reload value does not change the count in progress. It is used at the next reload event.
- R10: A transaction with `bus_priv` low has no effect on the registers:
  - a write changes nothing;
  - a read returns zero;
  - a read of 0x010 does not clear the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | Transaction valid in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | Transaction is privileged |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as `bus_sel` |
| irq_o | output | 1 | One-cycle interrupt request per tick |

## Verification
The hardest case to reach is a reload write that arrives in the same clock as the counter's reload event. The counter must take the old value there, and the period after it must use the new one. The bench watches for an interrupt, writes a new reload in the very next cycle, and then times the following two ticks against arithmetic expectations. A sweep over reload values 0 to 12 holds a read of the live count open for three whole periods. Each cycle it compares the count and `irq_o` with values computed from the cycle number modulo N+1.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  localparam int unsigned OFS_CTRL    = 32'h10;
  localparam int unsigned OFS_RELOAD  = 32'h14;
  localparam int unsigned OFS_CURRENT = 32'h18;

  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_IE_BIT   = 1;
  localparam int unsigned CTRL_FLAG_BIT = 16;

  typedef enum logic [1:0] {
    RSEL_NONE,
    RSEL_CTRL,
    RSEL_RELOAD,
    RSEL_CURRENT
  } rsel_e;

  typedef struct packed {
    logic rd_ctrl;
    logic wr_ctrl;
    logic wr_reload;
    logic wr_current;
  } bus_cmd_t;

endpackage

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode
  import tick_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_priv,
  input  logic [ADDR_W-1:0] bus_addr,
  output bus_cmd_t          cmd,
  output rsel_e             rsel
);

  rsel_e target;
  logic  hit;

  always_comb begin
    target = RSEL_NONE;
    if (bus_addr == ADDR_W'(OFS_CTRL))         target = RSEL_CTRL;
    else if (bus_addr == ADDR_W'(OFS_RELOAD))  target = RSEL_RELOAD;
    else if (bus_addr == ADDR_W'(OFS_CURRENT)) target = RSEL_CURRENT;
  end

  assign hit = bus_sel & bus_priv;

  always_comb begin
    cmd            = '0;
    cmd.rd_ctrl    = hit & ~bus_wr & (target == RSEL_CTRL);
    cmd.wr_ctrl    = hit &  bus_wr & (target == RSEL_CTRL);
    cmd.wr_reload  = hit &  bus_wr & (target == RSEL_RELOAD);
    cmd.wr_current = hit &  bus_wr & (target == RSEL_CURRENT);
    rsel           = (hit & ~bus_wr) ? target : RSEL_NONE;
  end

endmodule

// File: rtl/tmr_config.sv
module tmr_config
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bus_cmd_t         cmd,
  input  logic [31:0]      wdata,
  output logic             en,
  output logic             ie,
  output logic [CNT_W-1:0] reload
);

  logic             en_q, en_d;
  logic             ie_q, ie_d;
  logic [CNT_W-1:0] reload_q, reload_d;

  always_comb begin
    en_d     = en_q;
    ie_d     = ie_q;
    reload_d = reload_q;
    if (cmd.wr_ctrl) begin
      en_d = wdata[CTRL_EN_BIT];
      ie_d = wdata[CTRL_IE_BIT];
    end
    if (cmd.wr_reload) reload_d = wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      ie_q     <= 1'b0;
      reload_q <= '0;
    end else begin
      if (cmd.wr_ctrl) begin
        en_q <= en_d;
        ie_q <= ie_d;
      end
      if (cmd.wr_reload) reload_q <= reload_d;
    end
  end

  assign en     = en_q;
  assign ie     = ie_q;
  assign reload = reload_q;

  // R9
  reload_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd.wr_reload |=> $stable(reload_q));

endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             tick
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;
  logic             at_zero, at_one;

  assign at_zero = (cnt_q == '0);
  assign at_one  = (cnt_q == ONE);
  assign tick    = en & ~clr & at_one;
  assign cnt_ce  = clr | en;

  always_comb begin
    if (clr)          cnt_d = '0;
    else if (at_zero) cnt_d = reload;
    else              cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R2
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && cnt_q == '0) |=> cnt_q == $past(reload));

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && cnt_q > ONE) |=> cnt_q == $past(cnt_q) - ONE);

  // R6
  cnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);

  // R8
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/tmr_event.sv
module tmr_event (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ie,
  input  logic clr,
  input  logic rd_ctrl,
  output logic flag,
  output logic irq
);

  logic flag_q, flag_d;
  logic irq_q, irq_d;

  always_comb begin
    if (tick)                flag_d = 1'b1;
    else if (clr || rd_ctrl) flag_d = 1'b0;
    else                     flag_d = flag_q;
    irq_d = tick & ie;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  assign flag = flag_q;
  assign irq  = irq_q;

  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> flag_q);

  // R4
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> flag_q);

  // R5
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(ie));

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_priv,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  bus_cmd_t         cmd;
  rsel_e            rsel;
  logic             en, ie, flag, tick;
  logic [CNT_W-1:0] reload, cnt;
  logic [31:0]      ctrl_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  tmr_bus_decode #(.ADDR_W(ADDR_W)) u_decode (
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .bus_priv(bus_priv),
    .bus_addr(bus_addr),
    .cmd     (cmd),
    .rsel    (rsel)
  );

  tmr_config #(.CNT_W(CNT_W)) u_config (
    .clk   (clk),
    .rst_n (rst_int_n),
    .cmd   (cmd),
    .wdata (bus_wdata),
    .en    (en),
    .ie    (ie),
    .reload(reload)
  );

  tmr_down_counter #(.CNT_W(CNT_W)) u_counter (
    .clk   (clk),
    .rst_n (rst_int_n),
    .en    (en),
    .clr   (cmd.wr_current),
    .reload(reload),
    .cnt   (cnt),
    .tick  (tick)
  );

  tmr_event u_event (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .tick   (tick),
    .ie     (ie),
    .clr    (cmd.wr_current),
    .rd_ctrl(cmd.rd_ctrl),
    .flag   (flag),
    .irq    (irq)
  );

  logic irq;

  always_comb begin
    ctrl_word                = '0;
    ctrl_word[CTRL_EN_BIT]   = en;
    ctrl_word[CTRL_IE_BIT]   = ie;
    ctrl_word[CTRL_FLAG_BIT] = flag;
  end

  always_comb begin
    case (rsel)
      RSEL_CTRL:    bus_rdata = ctrl_word;
      RSEL_RELOAD:  bus_rdata = 32'(reload);
      RSEL_CURRENT: bus_rdata = 32'(cnt);
      default:      bus_rdata = '0;
    endcase
  end

  assign irq_o = irq;

  // R10
  unpriv_rd_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_sel && !bus_priv) |-> bus_rdata == '0);

  // R7
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_sel && !bus_wr && (bus_addr == ADDR_W'(OFS_RELOAD) ||
     bus_addr == ADDR_W'(OFS_CURRENT))) |-> (bus_rdata >> CNT_W) == '0);

endmodule

// File: tb/tick_timer_tb.sv
`timescale 1ns/1ps
module tick_timer_tb;

  localparam logic [7:0] A_CTRL = 8'h10;
  localparam logic [7:0] A_RLD  = 8'h14;
  localparam logic [7:0] A_CUR  = 8'h18;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr, bus_priv;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_o;
  int          checks = 0;
  int          errors = 0;

  always #2 clk = ~clk;

  tick_timer u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_priv (bus_priv),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq_o    (irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic do_wr(input logic [7:0] a, input logic [31:0] d, input logic p);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_priv = p;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [7:0] a, input logic p, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_priv = p;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic run_period(input int n);
    logic [31:0] v;
    do_wr(A_CTRL, 32'h0, 1'b1);
    do_wr(A_RLD, 32'(n), 1'b1);
    do_wr(A_CUR, 32'h0, 1'b1);
    do_wr(A_CTRL, 32'h3, 1'b1);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_CUR; bus_priv = 1'b1;
    for (int k = 1; k <= 3 * (n + 1) + 2; k++) begin
      @(negedge clk);
      // R2 R3: count follows N - ((k-1) mod (N+1))
      chk("R2 count", bus_rdata, 32'(n - ((k - 1) % (n + 1))));
      // R5: pulse once per period, never for N = 0
      chk("R5 irq", {31'b0, irq_o}, {31'b0, (n != 0) && (k % (n + 1) == 0)});
    end
    bus_sel = 1'b0;
    do_wr(A_CTRL, 32'h0, 1'b1);
    do_rd(A_CTRL, 1'b1, v);
    chk(n == 0 ? "R3 no flag" : "R4 flag set", v, (n == 0) ? 32'h0 : 32'h0001_0000);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_priv = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    do_rd(A_CTRL, 1'b1, v); chk("R1 ctrl", v, 32'h0);
    do_rd(A_RLD,  1'b1, v); chk("R1 reload", v, 32'h0);
    do_rd(A_CUR,  1'b1, v); chk("R1 current", v, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    do_rd(8'h1C, 1'b1, v); chk("R7 unmapped", v, 32'h0);

    // R2 R3 R5 sweep over reload values
    for (int n = 0; n <= 12; n++) run_period(n);

    // R4 R5: interrupt enable clear, flag still set, read clears it
    do_wr(A_RLD, 32'd3, 1'b1);
    do_wr(A_CUR, 32'h0, 1'b1);
    do_wr(A_CTRL, 32'h1, 1'b1);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk("R5 irq masked", {31'b0, irq_o}, 32'h0);
    end
    do_wr(A_CTRL, 32'h0, 1'b1);
    do_rd(A_CTRL, 1'b1, v); chk("R4 flag first read", v, 32'h0001_0000);
    do_rd(A_CTRL, 1'b1, v); chk("R4 flag cleared by read", v, 32'h0);

    // R7 reserved bits and full-width reload
    do_wr(A_RLD, 32'hFFFF_FFFF, 1'b1);
    do_rd(A_RLD, 1'b1, v); chk("R7 reload width", v, 32'h00FF_FFFF);
    do_wr(A_CUR, 32'h0, 1'b1);
    do_wr(A_CTRL, 32'h1, 1'b1);
    do_rd(A_CUR, 1'b1, v); chk("R6 cleared before load", v, 32'h0);
    do_rd(A_CUR, 1'b1, v); chk("R7 live max", v, 32'h00FF_FFFF);
    do_rd(A_CUR, 1'b1, v); chk("R7 live step", v, 32'h00FF_FFFE);

    // R6: clear mid-run drops flag, next clock loads
    do_wr(A_RLD, 32'd2, 1'b1);
    do_wr(A_CUR, 32'h0, 1'b1);
    do_wr(A_CTRL, 32'h3, 1'b1);
    repeat (8) @(negedge clk);
    do_wr(A_CUR, 32'hDEAD_BEEF, 1'b1);
    do_rd(A_CTRL, 1'b1, v); chk("R6 flag cleared", v, 32'h3);
    do_rd(A_CUR, 1'b1, v); chk("R6 load after clear", v, 32'd2);

    // R8: disabled count holds
    do_wr(A_CTRL, 32'h0, 1'b1);
    do_rd(A_CUR, 1'b1, v);
    repeat (5) @(negedge clk);
    do_rd(A_CUR, 1'b1, v2); chk("R8 hold", v2, v);

    // R9: reload written at the reload event applies one period later
    do_wr(A_RLD, 32'd9, 1'b1);
    do_wr(A_CUR, 32'h0, 1'b1);
    do_wr(A_CTRL, 32'h3, 1'b1);
    repeat (10) @(negedge clk);
    chk("R9 first tick", {31'b0, irq_o}, 32'h1);
    do_wr(A_RLD, 32'd4, 1'b1);
    do_rd(A_CUR, 1'b1, v); chk("R9 old reload used", v, 32'd9);
    for (int j = 1; j <= 14; j++) begin
      @(negedge clk);
      chk("R9 tick timing", {31'b0, irq_o}, {31'b0, (j == 8) || (j == 13)});
    end

    // R10: unprivileged access
    do_wr(A_CTRL, 32'h0, 1'b1);
    do_wr(A_RLD, 32'h55, 1'b0);
    do_rd(A_RLD, 1'b1, v); chk("R10 write ignored", v, 32'd4);
    do_rd(A_RLD, 1'b0, v); chk("R10 read zero", v, 32'h0);
    do_rd(A_CTRL, 1'b0, v); chk("R10 ctrl read zero", v, 32'h0);
    do_rd(A_CTRL, 1'b1, v); chk("R10 flag kept", v, 32'h0001_0000);
    do_rd(A_CUR, 1'b1, v);
    do_wr(A_CUR, 32'h0, 1'b0);
    do_rd(A_CUR, 1'b1, v2); chk("R10 clear ignored", v2, v);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule